// File: doc/BRIEF.md
# Software Transfer Start Register

This block is an 8-bit control register that lets the CPU launch a data transfer by software and pick the vector used for that launch. It sits on a plain register bus with a decoded select, a read strobe, a write strobe and byte-wide data in each direction. The top bit enables software launch; the low seven bits give a vector number, which is turned into a 16-bit vector-table address by adding a fixed base to the number shifted left by one place.

While the enable bit is set and no software transfer is running, the block raises an activation request toward the transfer engine. The engine acknowledges the start and later reports the end of the transfer, along with two flags: whether the programmed count has run out and whether the interrupt-on-end mode is selected. Depending on those flags, the block either clears the enable bit by itself or keeps it set. Software can clear the enable bit only by first reading the register while the bit is 1, then writing 0.

Top module: `sw_start_reg`

## Requirements
- R1: After reset, and in the cycle after `standby` is high, the whole register reads 0x00 and the read-before-clear permission is withdrawn.
- R2: When `sel` and `rdEn` are high, `rdData` shows the register in that same cycle, with the enable at bit 7 and the vector number at bits 6:0. Otherwise `rdData` is 0x00. A write of bits 6:0 is stored and can be read back from the next cycle on.
- R3: `vecAddr` always equals 0x0400 + (vector number << 1). Vector 0x10 gives 0x0420.
- R4: A write with bit 7 at 1 sets the enable bit in every state.
- R5: A write with bit 7 at 0 clears the enable bit only when a read with the enable at 1 came earlier and no write came in between. Any write withdraws the permission. An unpermitted write of 0 leaves the enable bit unchanged.
- R6: `actReq` is high exactly while the enable bit is 1 and no software transfer is running. It goes low in the cycle after `startAck` is seen with `actReq` high.
- R7: When `xferEnd` ends a running software transfer with `irqOnEnd` = 0 and `countDone` = 0, the enable bit is 0 from the next cycle.
- R8: The enable bit stays set when the transfer ends with `irqOnEnd` = 1 or `countDone` = 1. A permitted write of 0 while a transfer is running leaves it set.
- R9: If a write with bit 7 at 1 comes in the same cycle as a hardware clear, the enable bit is 1 afterwards.
- R10: `xferEnd` has no effect on the enable bit while no software transfer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Synchronous return to the reset value |
| sel | input | 1 | Register select from the address decoder |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid in the cycle of the read strobe |
| xferEnd | input | 1 | End of the current transfer, one cycle pulse |
| countDone | input | 1 | Programmed transfer count has run out |
| irqOnEnd | input | 1 | Interrupt-on-end mode selected |
| startAck | input | 1 | Engine accepts the activation request |
| actReq | output | 1 | Software activation request |
| vecAddr | output | 16 | Vector-table address for the software launch |

## Verification
`rdData`, `actReq` and `vecAddr` are combinational, so the bench drives each bus and engine stimulus just after a falling edge. It compares these outputs 1 ns later, in that same cycle. Stored effects of a write, standby, acknowledge or transfer end are due one rising edge later. The bench's reference model therefore updates its state after the comparison, and the next step's comparison checks that state in the following cycle.

// File: rtl/sw_start_pkg.sv
package sw_start_pkg;
  // Strobes from control to datapath, one per register action.
  typedef struct packed {
    logic wipe;     // return to reset value
    logic loadVec;  // take vector bits from write data
    logic setEn;    // enable bit to 1
    logic clrEn;    // enable bit to 0
  } ctlStrobes_t;
endpackage

// File: rtl/sw_start_ctl.sv
module sw_start_ctl
  import sw_start_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        standby,
  input  logic        sel,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic        wrEnBit,
  input  logic        enQ,
  input  logic        xferEnd,
  input  logic        countDone,
  input  logic        irqOnEnd,
  input  logic        startAck,
  output ctlStrobes_t strb,
  output logic        busyQ,
  output logic        actReq
);
  logic armedQ;
  logic busRd, busWr;
  logic autoClr, cpuClr;

  assign busRd = sel && rdEn;
  assign busWr = sel && wrEn;

  assign actReq  = enQ && !busyQ;
  assign autoClr = xferEnd && busyQ && !irqOnEnd && !countDone;
  assign cpuClr  = busWr && !wrEnBit && armedQ && !busyQ;

  always_comb begin
    strb         = '0;
    strb.wipe    = standby;
    strb.loadVec = busWr;
    strb.setEn   = busWr && wrEnBit;
    strb.clrEn   = !strb.setEn && (cpuClr || autoClr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      busyQ  <= 1'b0;
    end else if (standby) begin
      armedQ <= 1'b0;
      busyQ  <= 1'b0;
    end else begin
      if (busWr)
        armedQ <= 1'b0;
      else if (busRd && enQ)
        armedQ <= 1'b1;

      if (xferEnd && busyQ)
        busyQ <= 1'b0;
      else if (actReq && startAck)
        busyQ <= 1'b1;
    end
  end
endmodule

// File: rtl/sw_start_dp.sv
module sw_start_dp
  import sw_start_pkg::*;
#(
  parameter int          VEC_W    = 7,
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] VEC_BASE = 16'h0400,
  parameter int          VEC_SHL  = 1,
  localparam int         REG_W    = VEC_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic              rdSel,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  output logic              enQ,
  output logic [VEC_W-1:0]  vecQ,
  output logic [ADDR_W-1:0] vecAddr
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ  <= 1'b0;
      vecQ <= '0;
    end else if (strb.wipe) begin
      enQ  <= 1'b0;
      vecQ <= '0;
    end else begin
      if (strb.loadVec) vecQ <= wrData[VEC_W-1:0];
      if (strb.setEn)      enQ <= 1'b1;
      else if (strb.clrEn) enQ <= 1'b0;
    end
  end

  assign rdData  = rdSel ? {enQ, vecQ} : '0;
  assign vecAddr = ADDR_W'(VEC_BASE) + (ADDR_W'(vecQ) << VEC_SHL);
endmodule

// File: rtl/sw_start_reg.sv
module sw_start_reg
  import sw_start_pkg::*;
#(
  parameter int  VEC_W  = 7,
  parameter int  ADDR_W = 16,
  localparam int REG_W  = VEC_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              standby,
  input  logic              sel,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic              xferEnd,
  input  logic              countDone,
  input  logic              irqOnEnd,
  input  logic              startAck,
  output logic              actReq,
  output logic [ADDR_W-1:0] vecAddr
);
  ctlStrobes_t      strb;
  logic             enQ;
  logic             busyQ;
  logic [VEC_W-1:0] vecQ;

  sw_start_ctl u_ctl (
    .clk(clk), .rstN(rstN), .standby(standby),
    .sel(sel), .rdEn(rdEn), .wrEn(wrEn), .wrEnBit(wrData[REG_W-1]),
    .enQ(enQ), .xferEnd(xferEnd), .countDone(countDone),
    .irqOnEnd(irqOnEnd), .startAck(startAck),
    .strb(strb), .busyQ(busyQ), .actReq(actReq)
  );

  sw_start_dp #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(sel && rdEn),
    .wrData(wrData), .rdData(rdData), .enQ(enQ), .vecQ(vecQ),
    .vecAddr(vecAddr)
  );
endmodule

// File: rtl/sw_start_chk.sv
module sw_start_chk #(
  parameter int VEC_W  = 7,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              standby,
  input logic              sel,
  input logic              wrEn,
  input logic [VEC_W:0]    wrData,
  input logic              xferEnd,
  input logic              countDone,
  input logic              irqOnEnd,
  input logic              startAck,
  input logic              actReq,
  input logic [ADDR_W-1:0] vecAddr,
  input logic              enQ,
  input logic              busyQ,
  input logic [VEC_W-1:0]  vecQ
);
  // R1
  standby_wipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> (!enQ && vecQ == '0));

  // R3
  vec_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sel && wrEn && !standby) |=>
      vecAddr == ADDR_W'(16'h0400) + (ADDR_W'($past(wrData[VEC_W-1:0])) << 1));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sel && wrEn && wrData[VEC_W] && !standby) |=> enQ);

  // R6
  req_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actReq && startAck && !standby) |=> !actReq);

  // R7
  auto_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && xferEnd && !irqOnEnd && !countDone && !(sel && wrEn && wrData[VEC_W]))
      |=> !enQ);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && enQ && !standby && !(xferEnd && !irqOnEnd && !countDone)) |=> enQ);

  // R10
  idle_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busyQ && enQ && !standby && !(sel && wrEn)) |=> enQ);
endmodule

bind sw_start_reg sw_start_chk #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .standby(standby), .sel(sel), .wrEn(wrEn),
  .wrData(wrData), .xferEnd(xferEnd), .countDone(countDone),
  .irqOnEnd(irqOnEnd), .startAck(startAck), .actReq(actReq),
  .vecAddr(vecAddr), .enQ(enQ), .busyQ(busyQ), .vecQ(vecQ)
);

// File: tb/tb_sw_start_reg.sv
module tb_sw_start_reg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        standby = 1'b0, sel = 1'b0, rdEn = 1'b0, wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        xferEnd = 1'b0, countDone = 1'b0, irqOnEnd = 1'b0, startAck = 1'b0;
  logic        actReq;
  logic [15:0] vecAddr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference state
  bit       mEn, mArmed, mBusy;
  bit [6:0] mVec;

  sw_start_reg dut (
    .clk(clk), .rstN(rstN), .standby(standby), .sel(sel), .rdEn(rdEn),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .xferEnd(xferEnd),
    .countDone(countDone), .irqOnEnd(irqOnEnd), .startAck(startAck),
    .actReq(actReq), .vecAddr(vecAddr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] expAddr(bit [6:0] v);
    return 16'h0400 + {8'h00, v, 1'b0};
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One bus/engine cycle: drive after falling edge, compare, advance model.
  task automatic step(string tag, bit s, bit r, bit w, logic [7:0] d,
                      bit e, bit c, bit irq, bit ack, bit stb);
    bit busWr, busRd;
    bit nEn, nArm, nBusy;
    bit [6:0] nVec;
    @(negedge clk);
    sel = s; rdEn = r; wrEn = w; wrData = d;
    xferEnd = e; countDone = c; irqOnEnd = irq; startAck = ack; standby = stb;
    #1;
    busWr = s && w; busRd = s && r;
    check("R6 actReq", {15'd0, actReq}, {15'd0, mEn && !mBusy});
    check("R3 vecAddr", vecAddr, expAddr(mVec));
    check({tag, " rdData"}, {8'd0, rdData}, busRd ? {8'd0, mEn, mVec} : 16'd0);
    if (stb) begin
      nEn = 0; nVec = 0; nArm = 0; nBusy = 0;
    end else begin
      nVec = busWr ? d[6:0] : mVec;
      if (busWr && d[7]) nEn = 1;
      else if (busWr && mArmed && !mBusy) nEn = 0;
      else if (e && mBusy && !irq && !c) nEn = 0;
      else nEn = mEn;
      nArm = busWr ? 1'b0 : ((busRd && mEn) ? 1'b1 : mArmed);
      if (e && mBusy) nBusy = 0;
      else if (mEn && !mBusy && ack) nBusy = 1;
      else nBusy = mBusy;
    end
    mEn = nEn; mVec = nVec; mArmed = nArm; mBusy = nBusy;
  endtask

  task automatic wr(string tag, logic [7:0] d);
    step(tag, 1, 0, 1, d, 0, 0, 0, 0, 0);
  endtask
  task automatic rd(string tag);
    step(tag, 1, 1, 0, 8'h00, 0, 0, 0, 0, 0);
  endtask
  task automatic ack();
    step("R6", 0, 0, 0, 8'h00, 0, 0, 0, 1, 0);
  endtask
  task automatic xend(string tag, bit c, bit irq);
    step(tag, 0, 0, 0, 8'h00, 1, c, irq, 0, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    int seedVal;
    mEn = 0; mArmed = 0; mBusy = 0; mVec = 0;
    seedVal = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset value
    rd("R1");
    // R2 / R3 vector write, readback, address
    wr("R2", 8'h10);
    rd("R2");
    check("R3 vecAddr 0x10", vecAddr, 16'h0420);
    // R4 set
    wr("R4", 8'h95);
    rd("R4");
    // R5 unpermitted clear: the write disarms, then a write of 0 is ignored
    wr("R5", 8'h85);
    wr("R5", 8'h05);
    rd("R5");
    check("R5 enable held", {8'd0, rdData}, 16'h0085);
    wr("R5", 8'h05);
    rd("R5");
    check("R5 enable cleared", {8'd0, rdData}, 16'h0005);
    // R6 / R7 launch, ack, end with auto clear
    wr("R6", 8'h81);
    ack();
    step("R6", 0, 0, 0, 8'h00, 0, 0, 0, 0, 0);
    xend("R7", 0, 0);
    rd("R7");
    // R8 hold on interrupt mode, on count done, and against CPU clear while busy
    wr("R8", 8'h82);
    ack();
    xend("R8", 0, 1);
    rd("R8");
    ack();
    xend("R8", 1, 0);
    rd("R8");
    ack();
    wr("R8", 8'h82);
    rd("R8");
    wr("R8", 8'h02);
    rd("R8");
    check("R8 busy hold", {8'd0, rdData[7]}, 16'h0001);
    // R9 set beats auto clear
    step("R9", 1, 0, 1, 8'h83, 1, 0, 0, 0, 0);
    rd("R9");
    // R10 end while idle
    xend("R10", 0, 0);
    rd("R10");
    // R1 standby
    step("R1", 0, 0, 0, 8'h00, 0, 0, 0, 0, 1);
    rd("R1");
    wr("R1", 8'h00);
    rd("R1");

    // random traffic
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1: wr("R2", 8'($urandom));
        2, 3: rd("R2");
        4:    wr("R5", {1'b0, 7'($urandom)});
        5:    ack();
        6, 7: xend("R7", 1'($urandom), 1'($urandom));
        8:    step("R9", 1, 0, 1, 8'($urandom), 1, 1'($urandom), 1'($urandom),
                   1'($urandom), 0);
        default: step("R1", 0, 0, 0, 8'h00, 0, 0, 0, 0, ($urandom_range(0, 7) == 0));
      endcase
    end
    step("R6", 0, 0, 0, 8'h00, 0, 0, 0, 0, 0);
    finishRun();
  end
endmodule